// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Controller

This block follows the processor's power state and decides when a low-power state is over. Software enters a low-power state with a one-cycle request strobe and a 2-bit selector. Each state then waits for an interrupt that is allowed to end it. An interrupt is allowed only if interrupts are not globally disabled, the CPU does not mask it, and it is not routed to the data-transfer controller. Once a state ends, the block spends one cycle in an exception-handling state. In that cycle it raises a one-clock wake pulse that starts the core's exception sequence and turns the module clocks back on.

Two pins override everything else. A low standby pin forces hardware standby from any state. When the pin returns high, the block passes through a reset state. A low reset pin sends the block to that reset state from any state except hardware standby, and no mask is checked. Releasing the reset pin leads to exception handling and then to normal execution.

The states and their transitions are:
- RUN: normal execution. A strobe with selector 0 goes to SLEEP, 1 goes to SWSTBY, and 2 goes to CLKSTOP.
- SLEEP and CLKSTOP: each goes to EXCEPT on any qualified wake source.
- SWSTBY: goes to EXCEPT only on a qualified NMI or external IRQ.
- EXCEPT: goes to RUN after one cycle.
- HWSTBY: goes to RESET when the standby pin is high.
- RESET: goes to EXCEPT when the reset pin is high.
- Any state: goes to HWSTBY when the standby pin is low.
- Any state except HWSTBY: goes to RESET when the reset pin is low.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After system reset, mode_o is 0 (RUN), wake_o is 0 and mclk_en_o is 1.
- R2: In RUN, with both pins high, a slp_req pulse enters a low-power state on the next cycle. The selector picks the state: 0 gives mode 1 (SLEEP), 1 gives mode 2 (SWSTBY) and 2 gives mode 3 (CLKSTOP). Selector 3 is ignored, and slp_req is ignored outside RUN.
- R3: mclk_en_o is 0 in modes 2 (SWSTBY), 3 (CLKSTOP) and 4 (HWSTBY), and 1 in every other mode.
- R4: In SLEEP or CLKSTOP, any qualified source moves the block to mode 5 (EXCEPT) on the next cycle. The sources are nmi_i, any irq_i bit, tmr_irq_i and wdt_irq_i.
- R5: In SWSTBY, only a qualified nmi_i or irq_i ends the state; tmr_irq_i and wdt_irq_i leave it unchanged.
- R6: While int_dis_i is 1, no source ends a low-power state, NMI included.
- R7: While mask_nmi_only_i is 1, only nmi_i can end a low-power state.
- R8: A source whose dtc_route_i bit is 1 does not end a low-power state. Bit k (k<8) belongs to irq_i[k], bit 8 to tmr_irq_i and bit 9 to wdt_irq_i. NMI has no routing bit.
- R9: EXCEPT lasts exactly one cycle and is followed by RUN. wake_o is 1 only in EXCEPT, and mclk_en_o is 1 in that same cycle.
- R10: A low stby_n_i gives mode 4 (HWSTBY) on the next cycle from any state, whatever the other inputs are.
- R11: HWSTBY is held while stby_n_i is low. When stby_n_i is high, the next state is mode 6 (RESET).
- R12: With stby_n_i high, a low res_n_i gives RESET on the next cycle from any state except HWSTBY, with no mask checked. RESET is held while res_n_i is low; once res_n_i is high, the next state is EXCEPT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| stby_n_i | input | 1 | Standby pin, active low |
| res_n_i | input | 1 | Reset pin, active low |
| slp_req_i | input | 1 | One-cycle low-power entry strobe |
| slp_sel_i | input | 2 | Target state select (0 sleep, 1 software standby, 2 clock stop, 3 none) |
| nmi_i | input | 1 | Non-maskable interrupt request |
| irq_i | input | 8 | External interrupt requests |
| tmr_irq_i | input | 1 | 8-bit timer interrupt request |
| wdt_irq_i | input | 1 | Watchdog interrupt request |
| int_dis_i | input | 1 | Global interrupt disable |
| mask_nmi_only_i | input | 1 | CPU accepts only NMI |
| dtc_route_i | input | 10 | Per-source routing to the transfer controller |
| mode_o | output | 3 | Current state code |
| wake_o | output | 1 | One-cycle pulse that starts exception handling |
| mclk_en_o | output | 1 | Module clock enable |

## Verification
The hardest cases to reach are a wake source arriving while a qualifier blocks it in a specific low-power state. One example is a routed timer request in clock-stop mode; another is a watchdog request in software standby. The bench sweeps every combination of the three states, eleven sources, disable, mask and routing bit. It predicts the outcome arithmetically. When a wake is correctly refused, the bench uses the reset pin to bring the block back, which also exercises the reset path. The standby override is tested from EXCEPT by asserting the pin in the single cycle that state lasts.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

    typedef enum logic [2:0] {
        PM_RUN     = 3'd0,
        PM_SLEEP   = 3'd1,
        PM_SWSTBY  = 3'd2,
        PM_CLKSTOP = 3'd3,
        PM_HWSTBY  = 3'd4,
        PM_EXCEPT  = 3'd5,
        PM_RESET   = 3'd6
    } pm_state_t;

    localparam logic [1:0] SEL_SLEEP   = 2'd0;
    localparam logic [1:0] SEL_SWSTBY  = 2'd1;
    localparam logic [1:0] SEL_CLKSTOP = 2'd2;

    // Module clocks are gated in the deep states only
    function automatic logic clocks_on(input pm_state_t s);
        return !(s == PM_SWSTBY || s == PM_CLKSTOP || s == PM_HWSTBY);
    endfunction

endpackage

// File: rtl/wake_qualify.sv
module wake_qualify #(
    parameter int N_IRQ = 8,
    localparam int NSRC = N_IRQ + 3
) (
    input  logic             nmi,
    input  logic [N_IRQ-1:0] irq,
    input  logic             tmr,
    input  logic             wdt,
    input  logic             int_dis,
    input  logic             mask_nmi_only,
    input  logic [N_IRQ+1:0] route,
    output logic             wake_full,
    output logic             wake_ext
);
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] qual;

    // Source order: NMI, external IRQs, timer, watchdog
    assign raw = {wdt, tmr, irq, nmi};

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i == 0) begin : g_nmi
            assign qual[i] = raw[i] & ~int_dis;
        end else begin : g_mask
            assign qual[i] = raw[i] & ~int_dis & ~mask_nmi_only & ~route[i-1];
        end
    end

    assign wake_full = |qual;
    assign wake_ext  = |qual[N_IRQ:0];

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_wake_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stby_n,
    input  logic      res_n,
    input  logic      slp_req,
    input  logic [1:0] slp_sel,
    input  logic      wake_full,
    input  logic      wake_ext,
    input  logic      int_dis,
    output pm_state_t state_q
);
    pm_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PM_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!stby_n) begin
            state_d = PM_HWSTBY;
        end else if (state_q == PM_HWSTBY) begin
            state_d = PM_RESET;
        end else if (!res_n) begin
            state_d = PM_RESET;
        end else begin
            unique case (state_q)
                PM_RUN: begin
                    if (slp_req) begin
                        if (slp_sel == SEL_SLEEP)        state_d = PM_SLEEP;
                        else if (slp_sel == SEL_SWSTBY)  state_d = PM_SWSTBY;
                        else if (slp_sel == SEL_CLKSTOP) state_d = PM_CLKSTOP;
                    end
                end
                PM_SLEEP:   if (wake_full) state_d = PM_EXCEPT;
                PM_CLKSTOP: if (wake_full) state_d = PM_EXCEPT;
                PM_SWSTBY:  if (wake_ext)  state_d = PM_EXCEPT;
                PM_EXCEPT:  state_d = PM_RUN;
                PM_RESET:   state_d = PM_EXCEPT;
                default:    state_d = PM_RUN;
            endcase
        end
    end

    AST_STBY_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_n |=> state_q == PM_HWSTBY); // R10
    AST_HW_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PM_HWSTBY |=> (state_q == PM_HWSTBY || state_q == PM_RESET)); // R11
    AST_RES_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_n && !res_n && state_q != PM_HWSTBY) |=> state_q == PM_RESET); // R12
    AST_ENTRY_CLKSTOP: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_n && res_n && state_q == PM_RUN && slp_req && slp_sel == SEL_CLKSTOP)
        |=> state_q == PM_CLKSTOP); // R2
    AST_DIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_n && res_n && int_dis && state_q == PM_CLKSTOP) |=> state_q == PM_CLKSTOP); // R6
    AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_n && res_n && !wake_ext && state_q == PM_SWSTBY) |=> state_q == PM_SWSTBY); // R5

endmodule

// File: rtl/pwr_out.sv
module pwr_out
    import pwr_wake_pkg::*;
(
    input  pm_state_t  state_q,
    output logic [2:0] mode,
    output logic       wake,
    output logic       mclk_en
);
    always_comb begin
        mode    = state_q;
        wake    = (state_q == PM_EXCEPT);
        mclk_en = clocks_on(state_q);
    end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
    import pwr_wake_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stby_n_i,
    input  logic             res_n_i,
    input  logic             slp_req_i,
    input  logic [1:0]       slp_sel_i,
    input  logic             nmi_i,
    input  logic [N_IRQ-1:0] irq_i,
    input  logic             tmr_irq_i,
    input  logic             wdt_irq_i,
    input  logic             int_dis_i,
    input  logic             mask_nmi_only_i,
    input  logic [N_IRQ+1:0] dtc_route_i,
    output logic [2:0]       mode_o,
    output logic             wake_o,
    output logic             mclk_en_o
);
    logic      wake_full;
    logic      wake_ext;
    pm_state_t state_q;

    wake_qualify #(.N_IRQ(N_IRQ)) qual_i (
        .nmi           (nmi_i),
        .irq           (irq_i),
        .tmr           (tmr_irq_i),
        .wdt           (wdt_irq_i),
        .int_dis       (int_dis_i),
        .mask_nmi_only (mask_nmi_only_i),
        .route         (dtc_route_i),
        .wake_full     (wake_full),
        .wake_ext      (wake_ext)
    );

    pwr_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .stby_n    (stby_n_i),
        .res_n     (res_n_i),
        .slp_req   (slp_req_i),
        .slp_sel   (slp_sel_i),
        .wake_full (wake_full),
        .wake_ext  (wake_ext),
        .int_dis   (int_dis_i),
        .state_q   (state_q)
    );

    pwr_out out_i (
        .state_q (state_q),
        .mode    (mode_o),
        .wake    (wake_o),
        .mclk_en (mclk_en_o)
    );

    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> (!wake_o && mode_o == 3'd0) || !stby_n_i || !res_n_i
                   || $past(!stby_n_i) || $past(!res_n_i)); // R9
    AST_WAKE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> mclk_en_o); // R9
    AST_NO_WAKE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_n_i && res_n_i && mask_nmi_only_i && !nmi_i && mode_o == 3'd3)
        |=> mode_o == 3'd3); // R7

endmodule

// File: tb/pwr_wake_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_wake_ctrl_tb_top;
    localparam logic [2:0] M_RUN = 3'd0, M_SLP = 3'd1, M_SWS = 3'd2, M_CKS = 3'd3,
                           M_HWS = 3'd4, M_EXC = 3'd5, M_RST = 3'd6;

    logic clk = 0;
    logic rst_n = 0;
    logic stby_n = 1, res_n = 1, slp_req = 0;
    logic [1:0] slp_sel = 0;
    logic nmi = 0, tmr = 0, wdt = 0, int_dis = 0, msk = 0;
    logic [7:0] irq = 0;
    logic [9:0] route = 0;
    logic [2:0] mode;
    logic wake, mclk;
    int nchk = 0, nbad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwr_wake_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .stby_n_i(stby_n), .res_n_i(res_n),
        .slp_req_i(slp_req), .slp_sel_i(slp_sel), .nmi_i(nmi), .irq_i(irq),
        .tmr_irq_i(tmr), .wdt_irq_i(wdt), .int_dis_i(int_dis),
        .mask_nmi_only_i(msk), .dtc_route_i(route),
        .mode_o(mode), .wake_o(wake), .mclk_en_o(mclk)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(string tag, logic [2:0] em, logic ew);
        logic ec;
        ec = !(em == M_SWS || em == M_CKS || em == M_HWS);
        nchk++;
        if (mode !== em || wake !== ew || mclk !== ec) begin
            nbad++;
            $display("FAIL %s mode=%0d exp=%0d wake=%0d exp=%0d mclk=%0d exp=%0d",
                     tag, mode, em, wake, ew, mclk, ec);
        end
    endtask

    task automatic enter(logic [1:0] sel);
        slp_sel = sel; slp_req = 1; tick(); slp_req = 0;
    endtask

    task automatic via_reset_pin();
        res_n = 0; tick(); chk("R12", M_RST, 0);
        tick();            chk("R12", M_RST, 0);
        res_n = 1; tick(); chk("R12", M_EXC, 1);
        tick();            chk("R9", M_RUN, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        chk("R1", M_RUN, 0);

        // Sweep: mode x source x {disable, mask, route}
        for (int m = 0; m < 3; m++) begin
            for (int s = 0; s < 11; s++) begin
                for (int c = 0; c < 8; c++) begin
                    logic blocked, allowed, exp_w;
                    logic [2:0] lp;
                    string tag;
                    lp = 3'(m + 1);
                    enter(2'(m));
                    chk(m == 0 ? "R2" : "R3", lp, 0);
                    int_dis = c[0]; msk = c[1];
                    if (s == 0) route = {10{c[2]}};
                    else        route = 10'(c[2]) << (s - 1);
                    blocked = c[0] || (s > 0 && (c[1] || c[2]));
                    allowed = (m != 1) || (s <= 8);
                    exp_w   = !blocked && allowed;
                    if (c[0])                 tag = "R6";
                    else if (s > 0 && c[1])   tag = "R7";
                    else if (s > 0 && c[2])   tag = "R8";
                    else if (m == 1 && s > 8) tag = "R5";
                    else                      tag = "R4";
                    if (s == 0) nmi = 1;
                    else if (s <= 8) irq[s-1] = 1;
                    else if (s == 9) tmr = 1;
                    else wdt = 1;
                    tick();
                    nmi = 0; irq = 0; tmr = 0; wdt = 0;
                    if (exp_w) begin
                        chk(tag, M_EXC, 1);
                        int_dis = 0; msk = 0; route = 0;
                        tick(); chk("R9", M_RUN, 0);
                    end else begin
                        chk(tag, lp, 0);
                        int_dis = 0; msk = 0; route = 0;
                        tick(); chk(tag, lp, 0);
                        via_reset_pin();
                    end
                end
            end
        end

        // Reserved selector and strobe outside RUN
        enter(2'd3); chk("R2", M_RUN, 0);
        enter(2'd0); chk("R2", M_SLP, 0);
        enter(2'd2); chk("R2", M_SLP, 0);
        enter(2'd1); chk("R2", M_SLP, 0);
        nmi = 1; tick(); nmi = 0; chk("R4", M_EXC, 1);
        tick(); chk("R9", M_RUN, 0);

        // Standby pin from several states
        stby_n = 0; tick(); chk("R10", M_HWS, 0);
        stby_n = 1; tick(); chk("R11", M_RST, 0);
        tick(); chk("R11", M_EXC, 1);
        tick(); chk("R9", M_RUN, 0);

        enter(2'd2); chk("R2", M_CKS, 0);
        stby_n = 0; nmi = 1; res_n = 0; tick(); nmi = 0;
        chk("R10", M_HWS, 0);
        tick(); chk("R11", M_HWS, 0);
        stby_n = 1; tick(); chk("R11", M_RST, 0);
        tick(); chk("R12", M_RST, 0);
        res_n = 1; tick(); chk("R12", M_EXC, 1);
        tick(); chk("R9", M_RUN, 0);

        // Standby during the single EXCEPT cycle
        enter(2'd0); nmi = 1; tick(); nmi = 0; chk("R4", M_EXC, 1);
        stby_n = 0; tick(); chk("R10", M_HWS, 0);
        stby_n = 1; tick(); chk("R11", M_RST, 0);
        tick(); chk("R11", M_EXC, 1);
        tick(); chk("R9", M_RUN, 0);

        // Reset pin from sleep and from software standby with all masks set
        enter(2'd0); chk("R2", M_SLP, 0);
        via_reset_pin();
        enter(2'd1); chk("R2", M_SWS, 0);
        int_dis = 1; msk = 1; route = '1;
        via_reset_pin();
        int_dis = 0; msk = 0; route = 0;

        // Reset pin while in RUN
        via_reset_pin();

        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule